// File: doc/BRIEF.md
# SPI Master, Clock Idle High, Sample on Leading Edge

This block shifts one word per frame over a four-wire serial link as the clock-generating end. The serial clock rests high, and receive data is captured on each falling (leading) edge. Transmit data moves on each rising (trailing) edge. The first bit is presented when the frame select drops, half a clock period before the first edge. Between frames the clock and frame select sit high and the transmit line is forced low.

A host pulses `start_i` with a word and a length from 4 to 16 bits. When the last bit has been sampled, the received word appears with a one-cycle `done_o` pulse. The host can queue a second start while a frame is still in flight, before its last bit. That word then follows after a frame-select-high gap of exactly one serial clock period, without returning to idle.

The serial clock runs at the system clock divided by an even ratio of at least two. `half_div_i` sets the half-period. A mode input selects master or slave, and the block drives an active-low enable for the clock pad from it.

Top module: `spi_cpol1_master`

## Requirements
- R1: After reset and whenever `cs_no` is high, `sclk_o` is 1, `mosi_o` is 0, `done_o` is 0, and after reset `rx_data_o` is 0.
- R2: `sclk_oe_no` is 0 when `slave_mode_i` is 0, which enables the clock pad. It is 1 when `slave_mode_i` is 1.
- R3: A start in idle with `slave_mode_i`=0 drops `cs_no` and puts the word's most significant bit on `mosi_o` at once. The first falling edge of `sclk_o` follows H system cycles later, where H = max(`half_div_i`,1) latched at the start.
- R4: The serial clock period is 2H system cycles. Each low phase of `sclk_o` lasts H cycles.
- R5: `word_len_i` gives the bits per frame. Values below 4 act as 4 and values above 16 act as 16. A frame has exactly that many falling `sclk_o` edges.
- R6: Bits leave most significant first, from bit len-1 down to bit 0 of `tx_data_i`. `mosi_o` changes only on rising `sclk_o` edges, so it is stable at every falling edge.
- R7: `miso_i` is sampled at each falling edge. The bits are shifted in MSB first and right-aligned in `rx_data_o`, with the upper bits 0. They are presented with a one-cycle `done_o` pulse while `cs_no` is still low.
- R8: A start accepted while a frame is in flight, before its last bit begins, is queued. After the current frame, `cs_no` stays high exactly 2H cycles, then the queued word starts.
- R9: A start is ignored if it arrives during the last bit, the trailing half period or the gap of a frame, or while a word is already queued.
- R10: With `slave_mode_i`=1, a start in idle is ignored and `cs_no` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle transfer request |
| tx_data_i | input | 16 | Word to send, right-aligned |
| word_len_i | input | 5 | Bits per frame, clamped to 4..16 |
| half_div_i | input | 8 | Serial clock half-period in system cycles, 0 treated as 1 |
| slave_mode_i | input | 1 | 1 selects slave mode, which disables the clock pad and blocks starts |
| rx_data_o | output | 16 | Received word, right-aligned |
| done_o | output | 1 | One-cycle pulse with a new received word |
| sclk_o | output | 1 | Serial clock, idle high |
| cs_no | output | 1 | Frame select, active low |
| mosi_o | output | 1 | Serial transmit data |
| miso_i | input | 1 | Serial receive data |
| sclk_oe_no | output | 1 | Clock pad output enable, active low |

## Verification
A wrong state or bit index shows up on the link within the same frame. The edge count, the first-edge delay, the low-phase length or the received word goes off at the next falling edge or at the rise of the frame select. A stuck pending slot shows up one gap later, either as a frame the host never asked for or as a missing frame. A slip in the divider is caught within one half period through the phase-length checks.

// File: rtl/spi_m_pkg.sv
package spi_m_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI,
    ST_LO,
    ST_TAIL,
    ST_GAP
  } spi_st_e;
endpackage

// File: rtl/spi_m_tick.sv
module spi_m_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] half_q, cnt_q;

  assign tick_o = run_i && (cnt_q == half_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= DIV_W'(1);
      cnt_q  <= '0;
    end else if (restart_i) begin
      half_q <= (half_i == '0) ? DIV_W'(1) : half_i;
      cnt_q  <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r4_cnt_below_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < half_q);
endmodule

// File: rtl/spi_m_shift.sv
module spi_m_shift #(
  parameter int W  = 16,
  parameter int LW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [W-1:0]  data_i,
  input  logic [LW-1:0] len_i,
  input  logic          sample_i,
  input  logic          miso_i,
  input  logic          advance_i,
  input  logic          capture_i,
  output logic          tx_bit_o,
  output logic [W-1:0]  rx_o
);
  localparam logic [LW-1:0] WL = LW'(W);

  logic [W-1:0] tx_sr, rx_sr, rx_q;

  assign tx_bit_o = tx_sr[W-1];
  assign rx_o     = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr <= '0;
      rx_sr <= '0;
      rx_q  <= '0;
    end else begin
      if (load_i) begin
        tx_sr <= data_i << (WL - len_i);  // MSB of the word to the top
        rx_sr <= '0;
      end else begin
        if (advance_i) tx_sr <= {tx_sr[W-2:0], 1'b0};
        if (sample_i)  rx_sr <= {rx_sr[W-2:0], miso_i};
      end
      if (capture_i) rx_q <= rx_sr;
    end
  end

  a_r6_tx_hold_no_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !advance_i |=> $stable(tx_bit_o));
endmodule

// File: rtl/spi_m_ctrl.sv
module spi_m_ctrl
  import spi_m_pkg::*;
#(
  parameter int W     = 16,
  parameter int LW    = 5,
  parameter int MIN_L = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  tx_i,
  input  logic [LW-1:0] len_i,
  input  logic          slave_i,
  input  logic          tick_i,
  input  logic          tx_bit_i,
  output logic          run_o,
  output logic          load_o,
  output logic [W-1:0]  load_data_o,
  output logic [LW-1:0] load_len_o,
  output logic          sample_o,
  output logic          advance_o,
  output logic          capture_o,
  output logic          done_o,
  output logic          sclk_o,
  output logic          cs_no,
  output logic          mosi_o
);
  localparam logic [LW-1:0] LMIN = LW'(MIN_L);
  localparam logic [LW-1:0] LMAX = LW'(W);

  spi_st_e       st_q;
  logic [LW-1:0] bit_q, len_q, pend_len_q, len_clamped;
  logic [W-1:0]  pend_tx_q;
  logic          pend_v_q, gap2_q, done_q;
  logic          start_ok, last_bit, idle_go, gap_go, accept;

  assign len_clamped = (len_i < LMIN) ? LMIN : (len_i > LMAX) ? LMAX : len_i;
  assign start_ok    = start_i && !slave_i;
  assign last_bit    = (bit_q == len_q - 1'b1);
  assign idle_go     = (st_q == ST_IDLE) && start_ok;
  assign gap_go      = (st_q == ST_GAP) && tick_i && gap2_q && pend_v_q;
  assign accept      = start_ok && !pend_v_q && !last_bit &&
                       ((st_q == ST_HI) || (st_q == ST_LO));

  assign load_o      = idle_go || gap_go;
  assign load_data_o = (st_q == ST_GAP) ? pend_tx_q : tx_i;
  assign load_len_o  = (st_q == ST_GAP) ? pend_len_q : len_clamped;
  assign sample_o    = (st_q == ST_HI) && tick_i;
  assign advance_o   = (st_q == ST_LO) && tick_i && !last_bit;
  assign capture_o   = (st_q == ST_LO) && tick_i && last_bit;

  assign run_o  = (st_q != ST_IDLE);
  assign sclk_o = (st_q != ST_LO);
  assign cs_no  = (st_q == ST_IDLE) || (st_q == ST_GAP);
  assign mosi_o = !cs_no && tx_bit_i;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      len_q  <= LMIN;
      gap2_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= capture_o;
      unique case (st_q)
        ST_IDLE: if (idle_go) begin
          st_q  <= ST_HI;
          bit_q <= '0;
          len_q <= load_len_o;
        end
        ST_HI: if (tick_i) st_q <= ST_LO;
        ST_LO: if (tick_i) begin
          if (last_bit) st_q <= ST_TAIL;
          else begin
            st_q  <= ST_HI;
            bit_q <= bit_q + 1'b1;
          end
        end
        ST_TAIL: if (tick_i) begin
          st_q   <= ST_GAP;
          gap2_q <= 1'b0;
        end
        ST_GAP: if (tick_i) begin
          if (!gap2_q) gap2_q <= 1'b1;
          else if (pend_v_q) begin
            st_q  <= ST_HI;
            bit_q <= '0;
            len_q <= pend_len_q;
          end else st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q   <= 1'b0;
      pend_tx_q  <= '0;
      pend_len_q <= LMIN;
    end else if (accept) begin
      pend_v_q   <= 1'b1;
      pend_tx_q  <= tx_i;
      pend_len_q <= len_clamped;
    end else if (gap_go) begin
      pend_v_q <= 1'b0;
    end
  end

  a_r10_slave_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) && slave_i |=> (st_q == ST_IDLE));
  a_r8_pend_held_until_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_v_q && (st_q != ST_GAP) |=> pend_v_q);
  a_r9_no_queue_on_last_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_HI) || (st_q == ST_LO)) && last_bit && !pend_v_q |=> !pend_v_q);
  a_r7_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/spi_cpol1_master.sv
module spi_cpol1_master #(
  parameter int MAX_W = 16,
  parameter int MIN_W = 4,
  parameter int DIV_W = 8,
  localparam int LW   = $clog2(MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [MAX_W-1:0] tx_data_i,
  input  logic [LW-1:0]    word_len_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             slave_mode_i,
  output logic [MAX_W-1:0] rx_data_o,
  output logic             done_o,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic             sclk_oe_no
);
  logic             run, load, sample, advance, capture, tick, tx_bit;
  logic [MAX_W-1:0] load_data;
  logic [LW-1:0]    load_len;

  assign sclk_oe_no = slave_mode_i;  // pad enable active low: master drives clock

  spi_m_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni,
    .run_i(run), .restart_i(load), .half_i(half_div_i), .tick_o(tick)
  );

  spi_m_ctrl #(.W(MAX_W), .LW(LW), .MIN_L(MIN_W)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i, .tx_i(tx_data_i), .len_i(word_len_i), .slave_i(slave_mode_i),
    .tick_i(tick), .tx_bit_i(tx_bit),
    .run_o(run), .load_o(load), .load_data_o(load_data), .load_len_o(load_len),
    .sample_o(sample), .advance_o(advance), .capture_o(capture),
    .done_o, .sclk_o, .cs_no, .mosi_o
  );

  spi_m_shift #(.W(MAX_W), .LW(LW)) u_shift (
    .clk_i, .rst_ni,
    .load_i(load), .data_i(load_data), .len_i(load_len),
    .sample_i(sample), .miso_i, .advance_i(advance), .capture_i(capture),
    .tx_bit_o(tx_bit), .rx_o(rx_data_o)
  );

  a_r1_frame_high_lines_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o && !mosi_o);
  a_r7_done_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cs_no);
  a_r4_clock_low_only_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_o |-> !cs_no);
endmodule

// File: tb/tb_spi_cpol1_master.sv
module tb_spi_cpol1_master;
  typedef struct {
    logic [15:0] tx;
    int          len;
    logic [15:0] slv;
    bit          queued;
    int          half;
  } item_t;

  logic        clk_i = 0, rst_ni = 0, start_i = 0, slave_mode_i = 0, miso_i = 0;
  logic [15:0] tx_data_i = '0;
  logic [4:0]  word_len_i = 5'd8;
  logic [7:0]  half_div_i = 8'd2;
  logic [15:0] rx_data_o;
  logic        done_o, sclk_o, cs_no, mosi_o, sclk_oe_no;

  spi_cpol1_master dut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  int frames_pushed = 0, frames_done = 0;
  item_t exp_q[$];
  item_t cur;
  logic [15:0] slv_sr, word;
  int since_fall, low_cnt, gap_cnt, bits;
  bit prev_cs = 1, prev_sclk = 1, done_seen, first_seen, have_cur = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int eff_len(input int l);
    return (l < 4) ? 4 : (l > 16) ? 16 : l;
  endfunction

  function automatic logic [15:0] lmask(input int l);
    return 16'((32'd1 << l) - 1);
  endfunction

  task automatic send(input logic [15:0] tx, input int len, input logic [15:0] slv,
                      input bit queued, input bit expect_frame);
    item_t it;
    @(negedge clk_i);
    start_i    = 1'b1;
    tx_data_i  = tx;
    word_len_i = 5'(len);
    if (expect_frame) begin
      it.tx = tx; it.len = eff_len(len); it.slv = slv; it.queued = queued;
      it.half = (half_div_i == 0) ? 1 : int'(half_div_i);
      exp_q.push_back(it);
      frames_pushed++;
    end
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (frames_done != frames_pushed) @(negedge clk_i);
    repeat (8) @(negedge clk_i);
  endtask

  // monitor and slave model, all sampling at the falling system clock edge
  always @(negedge clk_i) if (rst_ni) begin
    if (prev_cs && !cs_no) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected frame", 1, 0);
        have_cur = 0;
      end else begin
        cur = exp_q.pop_front();
        have_cur = 1;
        if (cur.queued) chk(gap_cnt == 2 * cur.half, "R8 gap length", gap_cnt, 2 * cur.half);
        chk(mosi_o == cur.tx[cur.len-1], "R3 msb at frame fall", mosi_o, cur.tx[cur.len-1]);
        slv_sr = cur.slv << (16 - cur.len);
        miso_i = slv_sr[15];
      end
      since_fall = 0; bits = 0; word = '0; done_seen = 0; first_seen = 0; low_cnt = 0;
    end else if (!cs_no && have_cur) begin
      since_fall++;
      if (prev_sclk && !sclk_o) begin
        bits++;
        word = {word[14:0], mosi_o};
        low_cnt = 1;
        if (!first_seen) begin
          chk(since_fall == cur.half, "R3 first edge delay", since_fall, cur.half);
          first_seen = 1;
        end
      end else if (!sclk_o) low_cnt++;
      if (!prev_sclk && sclk_o) begin
        chk(low_cnt == cur.half, "R4 low phase", low_cnt, cur.half);
        slv_sr = {slv_sr[14:0], 1'b0};
        miso_i = slv_sr[15];
      end
      if (done_o) begin
        done_seen = 1;
        chk(rx_data_o == (cur.slv & lmask(cur.len)), "R7 rx word", rx_data_o,
            cur.slv & lmask(cur.len));
      end
    end
    if (!prev_cs && cs_no) begin
      if (have_cur) begin
        chk(bits == cur.len, "R5 edge count", bits, cur.len);
        chk(word == (cur.tx & lmask(cur.len)), "R6 msb-first word", word,
            cur.tx & lmask(cur.len));
        chk(done_seen, "R7 done within frame", done_seen, 1);
      end
      frames_done++;
      gap_cnt = 1;
    end else if (cs_no) gap_cnt++;
    if (cs_no) begin
      chk(sclk_o && !mosi_o, "R1 idle lines", {sclk_o, mosi_o}, 2'b10);
      chk(!done_o, "R7 no done outside frame", done_o, 0);
    end
    prev_cs = cs_no;
    prev_sclk = sclk_o;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(sclk_o && cs_no && !mosi_o && !done_o && rx_data_o == 0, "R1 reset state",
        {sclk_o, cs_no, mosi_o, done_o}, 4'b1100);
    chk(sclk_oe_no == 1'b0, "R2 master enables pad", sclk_oe_no, 0);
    slave_mode_i = 1;
    @(negedge clk_i);
    chk(sclk_oe_no == 1'b1, "R2 slave disables pad", sclk_oe_no, 1);
    slave_mode_i = 0;

    // single transfers, several lengths and dividers
    half_div_i = 2; send(16'h00A5, 8, 16'h003C, 0, 1); wait_idle();
    half_div_i = 1; send(16'h8001, 16, 16'hF0F0, 0, 1); wait_idle();
    half_div_i = 3; send(16'h0009, 4, 16'h0006, 0, 1); wait_idle();
    half_div_i = 0; send(16'h0155, 10, 16'h02AA, 0, 1); wait_idle();

    // R5 clamping
    half_div_i = 1; send(16'hFFF6, 2, 16'h0005, 0, 1); wait_idle();
    send(16'hC3A5, 20, 16'h5A3C, 0, 1); wait_idle();

    // R8 continuous, R9 third start while slot full
    half_div_i = 2;
    send(16'h0013, 5, 16'h000C, 0, 1);
    repeat (2) @(negedge clk_i);
    send(16'h000A, 5, 16'h0015, 1, 1);
    repeat (2) @(negedge clk_i);
    send(16'h001F, 5, 16'h0001, 0, 0);
    wait_idle();

    // R9 start during tail is ignored
    send(16'h0007, 4, 16'h0008, 0, 1);
    while (!done_o) @(negedge clk_i);
    send(16'h000F, 4, 16'h000F, 0, 0);
    wait_idle();
    repeat (30) @(negedge clk_i);
    chk(frames_done == frames_pushed && exp_q.size() == 0, "R9 late start ignored",
        frames_done, frames_pushed);

    // R10 slave mode blocks start
    slave_mode_i = 1;
    send(16'h00FF, 8, 16'h0000, 0, 0);
    repeat (40) @(negedge clk_i);
    chk(cs_no == 1'b1 && frames_done == frames_pushed, "R10 slave start ignored",
        frames_done, frames_pushed);
    slave_mode_i = 0;
    @(negedge clk_i);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule